// File: doc/BRIEF.md
# Parked Priority Bus Arbiter

This block decides which of N bus masters owns a shared bus. Each master has its own request, grant and release lines. The grant is one-hot. A master holds its request until it is granted and must not drive the bus before then. Once granted, the master keeps the bus for a tenure that ends when it raises its release line.

Lower indices normally win, so index 0 has the highest priority. An age counter keeps low-priority masters from waiting forever. A requester that has watched enough grants go to other masters is promoted above every non-promoted requester.

A master whose tenure has ended stays parked on the bus until some other master asks for it, and it may start a new tenure without any arbitration. The next owner is chosen combinationally from the live requests. The grant therefore moves in the same edge that takes the release, and no idle cycle is inserted between owners.

Top module: `bus_arbiter_park`

## Requirements
- R1: While reset is held, and after it until the first request, every grant bit is 0.
- R2: From the idle state (no grant), a request is granted at the next clock edge. Among simultaneous requesters without promotion, the lowest index wins.
- R3: The grant vector is always one-hot or all zero. Once any grant has been given, it is never all zero again until reset.
- R4: During a tenure, the owner keeps its grant until it asserts its own release. Requests from other masters, and release from non-owners, do not move the grant.
- R5: When the owner asserts release while another master requests, the grant moves to the arbitration winner at that same edge, with no cycle of all-zero grant.
- R6: When the owner asserts release and no other master requests, the owner stays granted (parked) for as long as no other master requests.
- R7: While the bus is parked, a request from any other master moves the grant to the winner at the next edge, with no release needed.
- R8: While parked, if the owner asserts its own request and no other master requests, the owner starts a new tenure. From then on, R4 applies until it releases again.
- R9: At each grant change, every requester that loses has its age incremented, saturating at AGE_LIMIT (default 3). A requester whose age equals AGE_LIMIT is promoted above all requesters that are not promoted; among promoted requesters, the lowest index wins. A master's age returns to 0 when it is granted.
- R10: A master that drops its request is no longer a candidate, and its age returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-master request, held until granted |
| rel | input | N | Per-master release, honoured only from the owner |
| gnt | output | N | One-hot grant, all zero only before the first grant |

## Verification
The assertions assume that release has meaning only on the owner's line, and that req and rel are stable around the rising edge. The bench meets this by changing every input on the falling edge. The random phase keeps each waiting request high until it is granted, apart from a rare deliberate withdrawal. It raises release only on the line of the master the reference model says owns the bus, and occasionally raises a stray release elsewhere so that the ignore rule is exercised too.

// File: rtl/bus_arbiter_park.sv
module bus_arbiter_park #(
  parameter int N         = 4,
  parameter int AGE_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] rel,
  output logic [N-1:0] gnt
);
  localparam int AW = $clog2(AGE_LIMIT + 1);
  localparam logic [AW-1:0] LIM = AW'(AGE_LIMIT);

  logic          parked;
  logic [AW-1:0] age [N];
  logic          busy, own_rel, own_req, hand;
  logic [N-1:0]  cand, aged, pool, win;

  assign busy    = |gnt;
  assign own_rel = |(rel & gnt);
  assign own_req = |(req & gnt);
  assign cand    = req & ~gnt;

  always_comb
    for (int j = 0; j < N; j++) aged[j] = cand[j] && (age[j] == LIM);

  assign pool = (|aged) ? aged : cand;
  assign win  = pool & (~pool + N'(1));
  assign hand = (|cand) && (!busy || parked || own_rel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt    <= '0;
      parked <= 1'b0;
    end else if (hand) begin
      gnt    <= win;
      parked <= 1'b0;
    end else if (busy && !parked && own_rel) begin
      parked <= 1'b1;
    end else if (busy && parked && own_req) begin
      parked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      if (!rst_n || !req[j])
        age[j] <= '0;
      else if (hand) begin
        if (win[j])
          age[j] <= '0;
        else if (cand[j] && age[j] != LIM)
          age[j] <= age[j] + AW'(1);
      end
    end
  end
endmodule

module bus_arbiter_park_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] rel,
  input logic [N-1:0] gnt,
  input logic         parked
);
  // R3
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  never_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (|gnt));

  // R2
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gnt)) |-> (|(gnt & $past(req))));

  // R4
  tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !parked && !(|(rel & gnt))) |=> $stable(gnt));

  // R5
  overlap_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & rel)) && !parked && (|(req & ~gnt))) |=> ((|gnt) && !$stable(gnt)));

  // R6
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|(req & ~gnt))) |=> $stable(gnt));
endmodule

bind bus_arbiter_park bus_arbiter_park_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .rel(rel), .gnt(gnt), .parked(parked)
);

// File: tb/test_bus_arbiter_park.sv
module test_bus_arbiter_park;
  localparam int N = 4;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N-1:0] exp_gnt = '0;
  bit exp_park = 0;
  int age [N];

  always #10 clk = ~clk;

  bus_arbiter_park #(.N(N), .AGE_LIMIT(LIMIT)) i_bus_arbiter_park (
    .clk(clk), .rst_n(rst_n), .req(req), .rel(rel), .gnt(gnt)
  );

  task automatic model_step(input logic [N-1:0] r, input logic [N-1:0] l);
    logic [N-1:0] c;
    bit busy, hand, any_old;
    int w;
    busy = |exp_gnt;
    c = r & ~exp_gnt;
    hand = (|c) && (!busy || exp_park || (|(l & exp_gnt)));
    any_old = 0;
    for (int j = 0; j < N; j++) if (c[j] && age[j] >= LIMIT) any_old = 1;
    w = -1;
    for (int j = N - 1; j >= 0; j--)
      if (c[j] && (!any_old || age[j] >= LIMIT)) w = j;
    for (int j = 0; j < N; j++) begin
      if (!r[j]) age[j] = 0;
      else if (hand) begin
        if (j == w) age[j] = 0;
        else if (c[j] && age[j] < LIMIT) age[j] = age[j] + 1;
      end
    end
    if (hand) begin
      exp_gnt = '0;
      exp_gnt[w] = 1'b1;
      exp_park = 0;
    end else if (busy && !exp_park && (|(l & exp_gnt))) exp_park = 1;
    else if (busy && exp_park && (|(r & exp_gnt))) exp_park = 0;
  endtask

  task automatic check(input string tag);
    checks++;
    if (gnt !== exp_gnt) begin
      failures++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp_gnt);
    end
    checks++;
    if (!$onehot0(gnt)) begin
      failures++;
      $display("FAIL R3: gnt=%b expected one-hot or zero", gnt);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] l, input string tag);
    req = r;
    rel = l;
    model_step(r, l);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r, l;
    void'($urandom(32'd4242));
    for (int j = 0; j < N; j++) age[j] = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    cyc(4'b0000, 4'b0000, "R1");
    cyc(4'b1110, 4'b0000, "R2");
    cyc(4'b1101, 4'b0101, "R4");
    cyc(4'b1101, 4'b0010, "R5");
    cyc(4'b1100, 4'b0001, "R5");
    cyc(4'b1011, 4'b0100, "R9");
    cyc(4'b0000, 4'b1000, "R6");
    cyc(4'b0000, 4'b0000, "R6");
    cyc(4'b0100, 4'b0000, "R7");
    cyc(4'b0000, 4'b0100, "R6");
    cyc(4'b0100, 4'b0000, "R8");
    cyc(4'b0011, 4'b0000, "R8");
    cyc(4'b0010, 4'b0000, "R10");
    cyc(4'b0010, 4'b0100, "R5");
    // R10: master 3 ages while waiting, withdraws, then loses to index 0
    cyc(4'b1011, 4'b0010, "R9");
    cyc(4'b1010, 4'b0001, "R9");
    cyc(4'b0011, 4'b0010, "R10");
    cyc(4'b1011, 4'b0000, "R10");

    r = req;
    for (int k = 0; k < 4000; k++) begin
      l = '0;
      for (int j = 0; j < N; j++) begin
        if (exp_gnt[j]) begin
          if ($urandom_range(0, 2) == 0) l[j] = 1'b1;
          r[j] = ($urandom_range(0, 7) == 0);
        end else if (r[j]) begin
          if ($urandom_range(0, 24) == 0) r[j] = 1'b0;
        end else begin
          r[j] = ($urandom_range(0, 3) == 0);
        end
        if (!exp_gnt[j] && $urandom_range(0, 15) == 0) l[j] = 1'b1;
      end
      cyc(r, l, "R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule